// File: doc/BRIEF.md
# Banked Bus Address Decoder

This block turns the split address of a 16-bit-address processor with a multiplexed bank byte into device selects. In the low half of each bus clock the processor places the bank byte on the data bus, and the decoder keeps a copy of it. In the high half the decoder joins that bank to the 16-bit address and drives one active-low select. The select goes to onboard SRAM, to the expansion memory window, to a dual UART, to one of three control registers, or to one of four 32-byte expansion I/O devices. It also drives the enable and direction of the expansion data buffer, and passes the low five address bits to the expansion port.

The block runs from a fast system clock `clk` and samples the bus clock `phi2` as a data input. A three-state phase machine follows the bus clock:

- **PH_IDLE** is the state after reset. The transition *idle_to_addr* leaves it on the first sample of `phi2` low.
- **PH_ADDR** is the bank-capture half. The transition *addr_to_data* leaves it on a sample of `phi2` high.
- **PH_DATA** is the select half. The transition *data_to_addr* leaves it on a sample of `phi2` low.

Selects are driven only in PH_DATA and only while `phi2` is high. A strap input, `sram_fitted`, tells the block whether onboard SRAM is present. When the strap is low, all RAM moves onto the expansion window.

Top module: `addr_decoder`

## Requirements
- R1: The bank byte is taken from `data_in` on every `clk` edge that samples `phi2` low, and is held unchanged while `phi2` stays high, so a data-bus change during the high half does not alter the decode.
- R2: Every select is high (inactive) in PH_ADDR and PH_IDLE. A select goes low one `clk` edge after `phi2` is sampled high, and all selects go high as soon as `phi2` goes low, with no clock edge needed.
- R3: With bank 0 and address bits 15:8 equal to 0x02, address bits 7:5 pick the slot. Slot 0 drives `reg_sel_n[0]` (interrupt status), slot 1 drives `reg_sel_n[1]` (write protect), slot 2 drives `reg_sel_n[2]` (interrupt mask) and slot 3 drives `uart_cs_n`.
- R4: Slots 4 to 7 of page 0x0002 drive `io_sel_n[0]` to `io_sel_n[3]`. `io_addr` always equals address bits 4:0.
- R5: With `sram_fitted`=1, full addresses 0x000000–0x0001FF and 0x000300–0x07FFFF drive `sram_cs_n`.
- R6: With `sram_fitted`=1, full addresses 0x080000–0x47FFFF drive `xmem_cs_n`.
- R7: With `sram_fitted`=0, `sram_cs_n` never goes low. Full addresses 0x000000–0x3FFFFF outside page 0x0002 drive `xmem_cs_n`, and page 0x0002 decodes as in R3 and R4.
- R8: Addresses above the top of the window select no device. With the strap high that is 0x480000 and up; with the strap low it is 0x400000 and up.
- R9: At most one select is low at any time.
- R10: `exp_buf_en_n` is low exactly when `xmem_cs_n` or any `io_sel_n` bit is low. `exp_buf_dir` equals `rw` (1 = read, buffer drives toward the processor).
- R11: While `rst_n` is low, every select and `exp_buf_en_n` are high, and the machine is in PH_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than phi2 |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Bus clock; low = bank half, high = select half |
| rw | input | 1 | 1 = read, 0 = write |
| sram_fitted | input | 1 | Strap: 1 = onboard SRAM present |
| data_in | input | 8 | Data bus, carries the bank byte while phi2 is low |
| addr | input | 16 | Low 16 address bits |
| sram_cs_n | output | 1 | Onboard SRAM select |
| xmem_cs_n | output | 1 | Expansion memory window select |
| uart_cs_n | output | 1 | Dual UART select |
| reg_sel_n | output | 3 | Control register selects: [0] status, [1] protect, [2] mask |
| io_sel_n | output | 4 | Expansion I/O device selects 1..4 |
| io_addr | output | 5 | Address bits 4:0 for expansion devices |
| exp_buf_en_n | output | 1 | Expansion data buffer enable |
| exp_buf_dir | output | 1 | Expansion buffer direction (follows rw) |

## Verification
The bank copy updates on each `clk` edge while `phi2` is low. Selects appear one edge after `phi2` is seen high and drop with no edge once `phi2` falls, and `io_addr` and the buffer direction follow their inputs at once. Each bus-cycle task drives inputs on the falling `clk` edge and reads the selects 2 ns after the first rising edge of the high half. It also checks the outputs 1 ns after `phi2` rises, before that edge, and 1 ns after `phi2` falls, so the exact edges of the select window are checked. The bank-hold case changes `data_in` in the same half-cycle that `phi2` rises, so a decoder that kept capturing would show the wrong device at the sample point.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA
    } phase_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SRAM,
        TGT_XMEM,
        TGT_STAT,
        TGT_PROT,
        TGT_MASK,
        TGT_UART,
        TGT_IO
    } target_t;
endpackage

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm
    import addr_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    output logic capture_en,
    output logic in_data
);
    phase_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (!phi2) state_d = PH_ADDR;   // idle_to_addr
            PH_ADDR: if (phi2)  state_d = PH_DATA;   // addr_to_data
            PH_DATA: if (!phi2) state_d = PH_ADDR;   // data_to_addr
            default:            state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        capture_en = !phi2;
        in_data    = (state_q == PH_DATA);
    end
endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic [BANK_W-1:0] d,
    output logic [BANK_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= '0;
        else if (capture_en) q <= d;
    end
endmodule

// File: rtl/addr_map_decode.sv
module addr_map_decode
    import addr_dec_pkg::*;
#(
    parameter int BANK_W   = 8,
    parameter int ADDR_W   = 16,
    parameter int SLOT_W   = 5,
    parameter int N_IO     = 4,
    parameter int IO_IDX_W = $clog2(N_IO),
    parameter logic [BANK_W+ADDR_W-1:0] SRAM_TOP  = 24'h07FFFF,
    parameter logic [BANK_W+ADDR_W-1:0] XMEM_BASE = 24'h080000,
    parameter logic [BANK_W+ADDR_W-1:0] XMEM_SIZE = 24'h400000,
    parameter logic [ADDR_W-9:0]        IO_PAGE   = 8'h02
) (
    input  logic [BANK_W-1:0]   bank,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                sram_fitted,
    output target_t             tgt,
    output logic [IO_IDX_W-1:0] io_idx
);
    localparam int FULL_W     = BANK_W + ADDR_W;
    localparam int SLOT_IDX_W = 8 - SLOT_W;
    localparam int FIRST_IO   = 4;
    localparam logic [FULL_W-1:0] XMEM_TOP = XMEM_BASE + XMEM_SIZE - FULL_W'(1);
    localparam logic [FULL_W-1:0] ALT_TOP  = XMEM_SIZE - FULL_W'(1);

    logic [FULL_W-1:0]     full;
    logic                  page_hit;
    logic [SLOT_IDX_W-1:0] slot;
    logic [SLOT_IDX_W-1:0] io_off;

    always_comb begin
        full     = {bank, addr};
        page_hit = (bank == '0) && (addr[ADDR_W-1:8] == IO_PAGE);
        slot     = addr[7:SLOT_W];
        io_off   = slot - SLOT_IDX_W'(FIRST_IO);
        tgt      = TGT_NONE;
        io_idx   = '0;
        if (page_hit) begin
            unique case (slot)
                SLOT_IDX_W'(0): tgt = TGT_STAT;
                SLOT_IDX_W'(1): tgt = TGT_PROT;
                SLOT_IDX_W'(2): tgt = TGT_MASK;
                SLOT_IDX_W'(3): tgt = TGT_UART;
                default: begin
                    if (32'(io_off) < N_IO) begin
                        tgt    = TGT_IO;
                        io_idx = IO_IDX_W'(io_off);
                    end
                end
            endcase
        end else if (sram_fitted) begin
            if (full <= SRAM_TOP)
                tgt = TGT_SRAM;
            else if (full >= XMEM_BASE && full <= XMEM_TOP)
                tgt = TGT_XMEM;
        end else if (full <= ALT_TOP) begin
            tgt = TGT_XMEM;
        end
    end
endmodule

// File: rtl/addr_select_drive.sv
module addr_select_drive
    import addr_dec_pkg::*;
#(
    parameter int N_IO     = 4,
    parameter int IO_IDX_W = $clog2(N_IO)
) (
    input  logic                active,
    input  target_t             tgt,
    input  logic [IO_IDX_W-1:0] io_idx,
    output logic                sram_cs_n,
    output logic                xmem_cs_n,
    output logic                uart_cs_n,
    output logic [2:0]          reg_sel_n,
    output logic [N_IO-1:0]     io_sel_n,
    output logic                exp_buf_en_n
);
    always_comb begin
        sram_cs_n    = !(active && tgt == TGT_SRAM);
        xmem_cs_n    = !(active && tgt == TGT_XMEM);
        uart_cs_n    = !(active && tgt == TGT_UART);
        reg_sel_n[0] = !(active && tgt == TGT_STAT);
        reg_sel_n[1] = !(active && tgt == TGT_PROT);
        reg_sel_n[2] = !(active && tgt == TGT_MASK);
        exp_buf_en_n = !(active && (tgt == TGT_XMEM || tgt == TGT_IO));
    end

    for (genvar g = 0; g < N_IO; g++) begin : g_io
        assign io_sel_n[g] = !(active && tgt == TGT_IO && io_idx == IO_IDX_W'(g));
    end
endmodule

// File: rtl/addr_decoder.sv
module addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int ADDR_W = 16,
    parameter int SLOT_W = 5,
    parameter int N_IO   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic              rw,
    input  logic              sram_fitted,
    input  logic [BANK_W-1:0] data_in,
    input  logic [ADDR_W-1:0] addr,
    output logic              sram_cs_n,
    output logic              xmem_cs_n,
    output logic              uart_cs_n,
    output logic [2:0]        reg_sel_n,
    output logic [N_IO-1:0]   io_sel_n,
    output logic [SLOT_W-1:0] io_addr,
    output logic              exp_buf_en_n,
    output logic              exp_buf_dir
);
    localparam int IO_IDX_W = $clog2(N_IO);

    logic                capture_en;
    logic                in_data;
    logic [BANK_W-1:0]   bank_q;
    target_t             tgt;
    logic [IO_IDX_W-1:0] io_idx;

    bus_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .phi2       (phi2),
        .capture_en (capture_en),
        .in_data    (in_data)
    );

    bank_latch #(.BANK_W(BANK_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .d          (data_in),
        .q          (bank_q)
    );

    addr_map_decode #(
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .N_IO   (N_IO)
    ) u_map (
        .bank        (bank_q),
        .addr        (addr),
        .sram_fitted (sram_fitted),
        .tgt         (tgt),
        .io_idx      (io_idx)
    );

    addr_select_drive #(.N_IO(N_IO)) u_drv (
        .active       (in_data && phi2 && rst_n),
        .tgt          (tgt),
        .io_idx       (io_idx),
        .sram_cs_n    (sram_cs_n),
        .xmem_cs_n    (xmem_cs_n),
        .uart_cs_n    (uart_cs_n),
        .reg_sel_n    (reg_sel_n),
        .io_sel_n     (io_sel_n),
        .exp_buf_en_n (exp_buf_en_n)
    );

    assign io_addr     = addr[SLOT_W-1:0];
    assign exp_buf_dir = rw;
endmodule

// File: rtl/addr_decoder_chk.sv
module addr_decoder_chk #(
    parameter int BANK_W = 8,
    parameter int ADDR_W = 16,
    parameter int N_IO   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phi2,
    input logic              sram_fitted,
    input logic [BANK_W-1:0] bank,
    input logic [ADDR_W-1:0] addr,
    input logic              sram_cs_n,
    input logic              xmem_cs_n,
    input logic              uart_cs_n,
    input logic [2:0]        reg_sel_n,
    input logic [N_IO-1:0]   io_sel_n,
    input logic              exp_buf_en_n
);
    logic [N_IO+5:0] sel_n;
    assign sel_n = {sram_cs_n, xmem_cs_n, uart_cs_n, reg_sel_n, io_sel_n};

    assert_single_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sel_n) <= 1);

    assert_high_phase_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n != '1) |-> phi2);

    assert_bank_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(phi2) |-> $stable(bank));

    assert_io_in_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel_n != '1) |-> (bank == '0 && addr[ADDR_W-1:8] == 8'h02 && addr[7]));

    assert_above_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({bank, addr} >= 24'h480000) |-> (sel_n == '1));

    assert_strap_no_sram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_fitted |-> sram_cs_n);

    assert_buffer_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exp_buf_en_n |-> (!xmem_cs_n || io_sel_n != '1));
endmodule

bind addr_decoder addr_decoder_chk #(
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W),
    .N_IO   (N_IO)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phi2         (phi2),
    .sram_fitted  (sram_fitted),
    .bank         (bank_q),
    .addr         (addr),
    .sram_cs_n    (sram_cs_n),
    .xmem_cs_n    (xmem_cs_n),
    .uart_cs_n    (uart_cs_n),
    .reg_sel_n    (reg_sel_n),
    .io_sel_n     (io_sel_n),
    .exp_buf_en_n (exp_buf_en_n)
);

// File: tb/addr_decoder_test.sv
module addr_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b1;
    logic        rw = 1'b1;
    logic        sram_fitted = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic [15:0] addr = 16'h0000;
    logic        sram_cs_n, xmem_cs_n, uart_cs_n, exp_buf_en_n, exp_buf_dir;
    logic [2:0]  reg_sel_n;
    logic [3:0]  io_sel_n;
    logic [4:0]  io_addr;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .sram_fitted(sram_fitted),
        .data_in(data_in), .addr(addr), .sram_cs_n(sram_cs_n), .xmem_cs_n(xmem_cs_n),
        .uart_cs_n(uart_cs_n), .reg_sel_n(reg_sel_n), .io_sel_n(io_sel_n),
        .io_addr(io_addr), .exp_buf_en_n(exp_buf_en_n), .exp_buf_dir(exp_buf_dir)
    );

    // Active-high view: {sram, xmem, uart, mask, prot, stat, io4..io1}
    function automatic logic [9:0] seen();
        return ~{sram_cs_n, xmem_cs_n, uart_cs_n, reg_sel_n[2], reg_sel_n[1],
                 reg_sel_n[0], io_sel_n};
    endfunction

    function automatic logic [9:0] model(input logic [7:0] b, input logic [15:0] a,
                                         input logic fit);
        logic [23:0] f;
        f = {b, a};
        if (b == 8'h00 && a[15:8] == 8'h02) begin
            case (a[7:5])
                3'd0: return 10'b0000010000;
                3'd1: return 10'b0000100000;
                3'd2: return 10'b0001000000;
                3'd3: return 10'b0010000000;
                default: return 10'(1) << (a[7:5] - 3'd4);
            endcase
        end
        if (fit) begin
            if (f <= 24'h07FFFF) return 10'b1000000000;
            if (f <= 24'h47FFFF) return 10'b0100000000;
            return '0;
        end
        if (f <= 24'h3FFFFF) return 10'b0100000000;
        return '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle; junk is put on data_in as phi2 rises (bank must be held).
    task automatic bus_cycle(input string req, input logic [7:0] b, input logic [15:0] a,
                             input logic fit, input logic r);
        logic [9:0] e;
        e = model(b, a, fit);
        @(negedge clk);
        phi2 = 1'b0; data_in = b; addr = a; rw = r; sram_fitted = fit;
        repeat (2) @(negedge clk);
        phi2 = 1'b1; data_in = ~b;
        #1 check({req, " pre-edge none (R2)"}, 32'(seen()), 32'd0);
        @(posedge clk); #2;
        check(req, 32'(seen()), 32'(e));
        check({req, " io_addr (R4)"}, 32'(io_addr), 32'(a[4:0]));
        check({req, " buffer (R10)"}, {30'd0, exp_buf_en_n, exp_buf_dir},
              {30'd0, !(e[8] || e[3:0] != 4'd0), r});
        @(negedge clk);
        phi2 = 1'b0;
        #1 check({req, " drop on phi2 low (R2)"}, 32'(seen()), 32'd0);
    endtask

    task automatic test_reset();
        check("R11 reset selects", 32'(seen()), 32'd0);
        check("R11 reset buffer", 32'(exp_buf_en_n), 32'd1);
    endtask

    task automatic test_bank_hold();
        bus_cycle("R1 bank held, io1", 8'h00, 16'h0285, 1'b1, 1'b1);
        bus_cycle("R1 bank held, bank 0x05 sram", 8'h05, 16'h0285, 1'b1, 1'b0);
    endtask

    task automatic test_page2();
        for (int s = 0; s < 8; s++)
            bus_cycle((s < 4) ? "R3 register slot" : "R4 io slot",
                      8'h00, 16'h0200 | 16'(s * 32 + (s * 7) % 32), 1'b1, 1'b1);
    endtask

    task automatic test_fitted_map();
        bus_cycle("R5 low ram 0x0001FF", 8'h00, 16'h01FF, 1'b1, 1'b1);
        bus_cycle("R5 ram 0x000300", 8'h00, 16'h0300, 1'b1, 1'b0);
        bus_cycle("R5 ram 0x07FFFF", 8'h07, 16'hFFFF, 1'b1, 1'b1);
        bus_cycle("R6 xmem 0x080000", 8'h08, 16'h0000, 1'b1, 1'b0);
        bus_cycle("R6 xmem 0x47FFFF", 8'h47, 16'hFFFF, 1'b1, 1'b1);
        bus_cycle("R8 none 0x480000", 8'h48, 16'h0000, 1'b1, 1'b1);
        bus_cycle("R8 none 0xFFFFFF", 8'hFF, 16'hFFFF, 1'b1, 1'b1);
    endtask

    task automatic test_strap_absent();
        bus_cycle("R7 xmem 0x000000", 8'h00, 16'h0000, 1'b0, 1'b1);
        bus_cycle("R7 xmem 0x3FFFFF", 8'h3F, 16'hFFFF, 1'b0, 1'b0);
        bus_cycle("R7 uart still decoded", 8'h00, 16'h0261, 1'b0, 1'b1);
        bus_cycle("R8 none 0x400000 unfitted", 8'h40, 16'h0000, 1'b0, 1'b1);
    endtask

    task automatic test_exclusive();
        bus_cycle("R9 io4 only", 8'h00, 16'h02FF, 1'b1, 1'b0);
        check("R9 single select", 32'($countones(model(8'h00, 16'h02FF, 1'b1))), 32'd1);
    endtask

    initial begin
        #(8 * 200000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_bank_hold();
        test_page2();
        test_fitted_map();
        test_strap_absent();
        test_exclusive();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule